// File: doc/BRIEF.md
# UART Register Front End

This block is the byte-wide register window of a simple UART. It sits on a 64-byte
bus window and decodes it into a two-entry mode register, a status register, a
command register, a data register that pushes transmit bytes and pops receive bytes,
an interrupt status and mask register, and two constant baud bytes. The bit-level
serial logic is outside the block. The transmit side hands whole bytes over a
valid/ready port. The receive side accepts whole bytes and break events into a small
receive FIFO.

Software drives the block through the command byte, which has three fields. Bits 6:4
select a miscellaneous action, bits 3:2 control the transmitter and bits 1:0 control
the receiver. The fields act in that order within one write. The transmitter is a
four-state machine that tracks whether it is enabled and whether a byte is pending:

- `TXS_OFF_EMPTY` is the reset state.
- `TXS_OFF_HELD` means the transmitter is disabled and a byte is pending.
- `TXS_ON_EMPTY` means the transmitter is enabled and nothing is pending.
- `TXS_ON_SEND` means the transmitter is enabled and a byte is being offered.

The transitions are:

- A data write moves any state to the matching pending state.
- An enable command moves OFF to ON.
- A disable command or a transmitter reset moves ON to OFF. A transmitter reset also drops the pending byte.
- A handshake, with `tx_ready` high while in `TXS_ON_SEND`, moves to `TXS_ON_EMPTY`.

The interrupt status register gathers transmit-ready, a selectable receive condition and a break flag. The interrupt output is raised when any of these bits is also set in the mask.

Top module: `uart_regfile`

## Requirements
- R1: The offset is 6 bits. Reads return: 0x00 the selected mode register, 0x04 status, 0x0C receive data, 0x14 interrupt status, 0x18 and 0x1C the baud parameters. All other offsets, including 0x08, read 0x00. Writes to 0x04, 0x10, 0x18 and 0x1C change nothing.
- R2: After reset the status reads 0x08, and the interrupt status and mode register read 0x00. `irq_out`, `tx_valid`, `rx_ready` and `bus_rdata` are all low.
- R3: A write to 0x00 stores into the mode register chosen by the pointer and then points the pointer at the second entry. Reads at 0x00 return the chosen entry without moving the pointer. Command misc value 1 points it back at the first entry.
- R4: Command bits 6:4 are misc, with 1 pointer reset, 2 receiver reset, 3 transmitter reset, 5 break-flag clear, and 0, 4, 6, 7 no effect. Bits 3:2 and 1:0 control the transmitter and the receiver: 1 enables, 2 disables, 0 and 3 have no effect. Within one write the enable/disable fields take effect after the misc action.
- R5: A receiver reset disables the receiver, empties the FIFO and clears status bits 0 and 1.
- R6: A write to 0x0C latches the byte and clears TxEMP (status bit 3). While the transmitter is enabled and TxEMP is clear, `tx_valid` is high and `tx_data` is held. The cycle in which `tx_ready` is sampled high sets TxEMP.
- R7: TxRDY (status bit 2) equals the transmitter enable. A transmitter reset disables the transmitter, sets TxEMP and drops any pending byte.
- R8: `rx_ready` is high when the receiver is enabled, the FIFO (4 entries) is not full and no break is presented. A byte with `rx_valid` and `rx_ready` is appended. Status bit 0 means not empty and bit 1 means full. A read of 0x0C returns the oldest byte and removes it. A read of 0x0C on an empty FIFO returns 0x00.
- R9: An `rx_break` cycle appends 0x00 whether or not the receiver is enabled, replacing the newest entry when the FIFO is full. It also sets interrupt status bit 2, which only misc value 5 clears.
- R10: Interrupt status bit 0 is TxRDY. Bit 1 is status bit 1 when mode register 0 bit 6 is set, and status bit 0 otherwise. Bit 2 is the break flag. `irq_out` is high when the interrupt status ANDed with the mask written at 0x14 is non-zero.
- R11: `bus_rdata` is registered. It carries the value read in the cycle after `bus_rd` and holds while no read is made. Status, interrupt status and `irq_out` show the effect of an access from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 1 | Masked interrupt request |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serial side takes the byte |
| rx_valid | input | 1 | Received byte presented |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | FIFO accepts a byte |
| rx_break | input | 1 | Break event, one cycle per event |

## Verification
Each access acts at the clock edge where its strobe is sampled. Read data appears on `bus_rdata` one cycle after the read strobe. Status, interrupt status, `irq_out` and `tx_valid` change one cycle after a write, a handshake or a receive push. The bench drives every strobe for one full cycle, from one falling edge to the next. It samples the outputs at the falling edge that ends the strobe, which is exactly one rising edge later. Where a result depends on a handshake, the bench holds `tx_ready` for exactly one rising edge and then samples.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

    localparam int OFS_W = 6;
    localparam int DW    = 8;

    localparam logic [OFS_W-1:0] OFS_MODE  = 6'h00;
    localparam logic [OFS_W-1:0] OFS_STAT  = 6'h04;
    localparam logic [OFS_W-1:0] OFS_CMD   = 6'h08;
    localparam logic [OFS_W-1:0] OFS_DATA  = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_IRQ   = 6'h14;
    localparam logic [OFS_W-1:0] OFS_BAUDA = 6'h18;
    localparam logic [OFS_W-1:0] OFS_BAUDB = 6'h1C;

    // mode register 0 bit that selects full instead of not-empty for the rx interrupt
    localparam int MODE_RXSEL_BIT = 6;

    typedef enum logic [1:0] {
        TXS_OFF_EMPTY,
        TXS_OFF_HELD,
        TXS_ON_EMPTY,
        TXS_ON_SEND
    } tx_state_e;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_en;
        logic tx_dis;
        logic rx_en;
        logic rx_dis;
    } cmd_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_regs_pkg::*;
(
    input  logic       cmd_wr,
    input  logic [6:0] cmd_byte,
    output cmd_t       cmd
);

    always_comb begin
        cmd = '0;
        if (cmd_wr) begin
            unique case (cmd_byte[6:4])
                3'd1:    cmd.ptr_rst = 1'b1;
                3'd2:    cmd.rx_rst  = 1'b1;
                3'd3:    cmd.tx_rst  = 1'b1;
                3'd5:    cmd.brk_clr = 1'b1;
                default: ;
            endcase
            unique case (cmd_byte[3:2])
                2'd1:    cmd.tx_en  = 1'b1;
                2'd2:    cmd.tx_dis = 1'b1;
                default: ;
            endcase
            unique case (cmd_byte[1:0])
                2'd1:    cmd.rx_en  = 1'b1;
                2'd2:    cmd.rx_dis = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             brk_push,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             not_empty,
    output logic             full
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [CW-1:0]    cnt_q, cnt_d, slot;

    always_comb begin
        mem_d = mem_q;
        cnt_d = cnt_q;
        slot  = '0;
        if (pop && cnt_q != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) mem_d[i] = mem_q[i+1];
            cnt_d = cnt_q - 1'b1;
        end
        if (brk_push) begin
            // full FIFO: the break byte replaces the newest entry
            slot = (cnt_d == CW'(DEPTH)) ? CW'(DEPTH - 1) : cnt_d;
            for (int i = 0; i < DEPTH; i++)
                if (CW'(i) == slot) mem_d[i] = '0;
            cnt_d = slot + 1'b1;
        end else if (push && cnt_d < CW'(DEPTH)) begin
            for (int i = 0; i < DEPTH; i++)
                if (CW'(i) == cnt_d) mem_d[i] = push_data;
            cnt_d = cnt_d + 1'b1;
        end
        if (flush) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            cnt_q <= cnt_d;
            mem_q <= mem_d;
        end
    end

    assign head      = mem_q[0];
    assign not_empty = (cnt_q != '0);
    assign full      = (cnt_q == CW'(DEPTH));

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
    import uart_regs_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_cmd,
    input  logic             dis_cmd,
    input  logic             rst_cmd,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [WIDTH-1:0] tx_data,
    output logic             tx_rdy,
    output logic             tx_emp
);

    tx_state_e        state_q, state_d;
    logic [WIDTH-1:0] data_q;
    logic             en_nx, pend_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXS_OFF_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= load_data;
    end

    always_comb begin
        en_nx   = en_cmd ? 1'b1 : ((dis_cmd || rst_cmd) ? 1'b0 : tx_rdy);
        pend_nx = load ? 1'b1 :
                  (rst_cmd || (tx_valid && tx_ready)) ? 1'b0 : !tx_emp;
        unique case ({en_nx, pend_nx})
            2'b00: state_d = TXS_OFF_EMPTY;
            2'b01: state_d = TXS_OFF_HELD;
            2'b10: state_d = TXS_ON_EMPTY;
            2'b11: state_d = TXS_ON_SEND;
        endcase
    end

    always_comb begin
        unique case (state_q)
            TXS_OFF_EMPTY: begin tx_valid = 1'b0; tx_rdy = 1'b0; tx_emp = 1'b1; end
            TXS_OFF_HELD:  begin tx_valid = 1'b0; tx_rdy = 1'b0; tx_emp = 1'b0; end
            TXS_ON_EMPTY:  begin tx_valid = 1'b0; tx_rdy = 1'b1; tx_emp = 1'b1; end
            TXS_ON_SEND:   begin tx_valid = 1'b1; tx_rdy = 1'b1; tx_emp = 1'b0; end
        endcase
    end

    assign tx_data = data_q;

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_regs_pkg::*;
#(
    parameter int         FIFO_DEPTH = 4,
    parameter logic [7:0] BAUD_A     = 8'h00,
    parameter logic [7:0] BAUD_B     = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_out,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       rx_ready,
    input  logic       rx_break
);

    cmd_t          cmd;
    logic [DW-1:0] mode_q [2];
    logic          ptr_q, rx_en_q, brk_q;
    logic [DW-1:0] mask_q, rdata_q, rd_mux, status, isr;
    logic [DW-1:0] rx_head;
    logic          rx_nonempty, rx_full, tx_rdy, tx_emp;
    logic          wr_mode, wr_cmd, wr_data, wr_mask, rd_pop;

    assign wr_mode = bus_wr && (bus_addr == OFS_MODE);
    assign wr_cmd  = bus_wr && (bus_addr == OFS_CMD);
    assign wr_data = bus_wr && (bus_addr == OFS_DATA);
    assign wr_mask = bus_wr && (bus_addr == OFS_IRQ);
    assign rd_pop  = bus_rd && (bus_addr == OFS_DATA);

    uart_cmd_decode u_cmd (
        .cmd_wr   (wr_cmd),
        .cmd_byte (bus_wdata[6:0]),
        .cmd      (cmd)
    );

    uart_tx_ctrl #(.WIDTH(DW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_cmd    (cmd.tx_en),
        .dis_cmd   (cmd.tx_dis),
        .rst_cmd   (cmd.tx_rst),
        .load      (wr_data),
        .load_data (bus_wdata),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_rdy    (tx_rdy),
        .tx_emp    (tx_emp)
    );

    assign rx_ready = rx_en_q && !rx_full && !rx_break;

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DW)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cmd.rx_rst),
        .push      (rx_valid && rx_ready),
        .push_data (rx_data),
        .brk_push  (rx_break),
        .pop       (rd_pop),
        .head      (rx_head),
        .not_empty (rx_nonempty),
        .full      (rx_full)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q[0] <= '0;
            mode_q[1] <= '0;
            ptr_q     <= 1'b0;
            rx_en_q   <= 1'b0;
            brk_q     <= 1'b0;
            mask_q    <= '0;
            rdata_q   <= '0;
        end else begin
            if (wr_mode) begin
                mode_q[ptr_q] <= bus_wdata;
                ptr_q         <= 1'b1;
            end else if (cmd.ptr_rst) begin
                ptr_q <= 1'b0;
            end
            if (cmd.rx_en)                     rx_en_q <= 1'b1;
            else if (cmd.rx_dis || cmd.rx_rst) rx_en_q <= 1'b0;
            if (rx_break)         brk_q <= 1'b1;
            else if (cmd.brk_clr) brk_q <= 1'b0;
            if (wr_mask) mask_q  <= bus_wdata;
            if (bus_rd)  rdata_q <= rd_mux;
        end
    end

    assign status = {4'b0000, tx_emp, tx_rdy, rx_full, rx_nonempty};
    assign isr    = {5'b00000, brk_q,
                     (mode_q[0][MODE_RXSEL_BIT] ? rx_full : rx_nonempty), tx_rdy};

    always_comb begin
        unique case (bus_addr)
            OFS_MODE:  rd_mux = mode_q[ptr_q];
            OFS_STAT:  rd_mux = status;
            OFS_DATA:  rd_mux = rx_nonempty ? rx_head : '0;
            OFS_IRQ:   rd_mux = isr;
            OFS_BAUDA: rd_mux = BAUD_A;
            OFS_BAUDB: rd_mux = BAUD_B;
            default:   rd_mux = '0;
        endcase
    end

    assign bus_rdata = rdata_q;
    assign irq_out   = |(isr & mask_q);

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       irq_out,
    input logic       tx_valid,
    input logic [7:0] tx_data,
    input logic       tx_ready,
    input logic       rx_ready,
    input logic       rx_break,
    input logic       rx_nonempty
);

    logic cmd_wr;
    assign cmd_wr = bus_wr && (bus_addr == 6'h08);

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !bus_wr) |=> (tx_valid && $stable(tx_data))); // R6

    AST_TX_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !bus_wr) |=> !tx_valid); // R6

    AST_TX_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[6:4] == 3'd3 && bus_wdata[3:2] != 2'd1) |=> !tx_valid); // R7

    AST_RX_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[6:4] == 3'd2 && bus_wdata[1:0] != 2'd1 && !rx_break)
        |=> (!rx_ready && !rx_nonempty)); // R5

    AST_BRK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_break && !(cmd_wr && bus_wdata[6:4] == 3'd2)) |=> rx_nonempty); // R9

    AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'h14 && bus_wdata == 8'h00) |=> !irq_out); // R10

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R11

endmodule

bind uart_regfile uart_regfile_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_out     (irq_out),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_ready    (tx_ready),
    .rx_ready    (rx_ready),
    .rx_break    (rx_break),
    .rx_nonempty (rx_nonempty)
);

// File: tb/uart_regfile_test.sv
`timescale 1ns/1ps
module uart_regfile_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_out, tx_valid, rx_ready;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0] rx_data = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_regfile #(.FIFO_DEPTH(4), .BAUD_A(8'h12), .BAUD_B(8'h34)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .rx_break(rx_break)
    );

    typedef struct packed {
        logic       is_rd;
        logic [5:0] addr;
        logic [7:0] val;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 6'h04, 8'h08, 4'd2},   // R2 status after reset
        '{1'b1, 6'h14, 8'h00, 4'd2},   // R2 interrupt status after reset
        '{1'b1, 6'h00, 8'h00, 4'd2},   // R2 mode after reset
        '{1'b0, 6'h00, 8'h40, 4'd3},   // R3 first mode entry
        '{1'b0, 6'h00, 8'h13, 4'd3},   // R3 second mode entry
        '{1'b1, 6'h00, 8'h13, 4'd3},   // R3 pointer on second
        '{1'b0, 6'h08, 8'h10, 4'd3},   // R3 pointer reset
        '{1'b1, 6'h00, 8'h40, 4'd3},   // R3 pointer on first
        '{1'b1, 6'h08, 8'h00, 4'd1},   // R1 command reads zero
        '{1'b1, 6'h18, 8'h12, 4'd1},   // R1 baud A
        '{1'b1, 6'h1C, 8'h34, 4'd1},   // R1 baud B
        '{1'b1, 6'h10, 8'h00, 4'd1},   // R1 unmapped
        '{1'b0, 6'h04, 8'hFF, 4'd1},   // R1 status write ignored
        '{1'b1, 6'h04, 8'h08, 4'd1},   // R1
        '{1'b0, 6'h08, 8'h04, 4'd7},   // R7 tx enable
        '{1'b1, 6'h04, 8'h0C, 4'd7},   // R7 TxRDY set
        '{1'b1, 6'h14, 8'h01, 4'd10},  // R10 isr bit0
        '{1'b0, 6'h08, 8'h0C, 4'd4},   // R4 reserved tx field
        '{1'b1, 6'h04, 8'h0C, 4'd4},   // R4 unchanged
        '{1'b0, 6'h08, 8'h08, 4'd7},   // R7 tx disable
        '{1'b1, 6'h04, 8'h08, 4'd7},   // R7 TxRDY clear
        '{1'b0, 6'h08, 8'h40, 4'd4},   // R4 misc 4 no effect
        '{1'b1, 6'h04, 8'h08, 4'd4},   // R4
        '{1'b0, 6'h08, 8'h35, 4'd4},   // R4 tx reset then enable, rx enable
        '{1'b1, 6'h04, 8'h0C, 4'd4},   // R4 enable wins after reset
        '{1'b0, 6'h08, 8'h2A, 4'd5},   // R5 rx reset, tx and rx disable
        '{1'b1, 6'h04, 8'h08, 4'd5},   // R5
        '{1'b1, 6'h3C, 8'h00, 4'd1},   // R1 unmapped top offset
        '{1'b1, 6'h00, 8'h40, 4'd1}    // R1 mode read leaves pointer
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [5:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic rx_push(input logic [7:0] d);
        @(negedge clk);
        rx_data = d; rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic brk_pulse();
        @(negedge clk);
        rx_break = 1'b1;
        @(negedge clk);
        rx_break = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!irq_out, "R2 irq", irq_out, 0);
        check(!tx_valid, "R2 tx_valid", tx_valid, 0);
        check(!rx_ready, "R2 rx_ready", rx_ready, 0);
        check(bus_rdata == 8'h00, "R2 rdata", bus_rdata, 0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_rd) begin
                @(negedge clk);
                bus_addr = VECS[i].addr; bus_rd = 1'b1;
                @(negedge clk);
                bus_rd = 1'b0;
                checks++;
                if (bus_rdata != VECS[i].val) begin
                    errors++;
                    $display("FAIL R%0d vector %0d actual=%0h expected=%0h",
                             VECS[i].req, i, bus_rdata, VECS[i].val);
                end
            end else begin
                wr(VECS[i].addr, VECS[i].val);
            end
        end

        // R6 transmit handshake
        wr(6'h08, 8'h04);
        wr(6'h0C, 8'hA5);
        check(tx_valid && tx_data == 8'hA5, "R6 offer", {tx_valid, tx_data}, 9'h1A5);
        rd_chk(6'h04, 8'h04, "R6 TxEMP clear");
        check(tx_valid, "R6 held", tx_valid, 1);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        check(!tx_valid, "R6 sent", tx_valid, 0);
        rd_chk(6'h04, 8'h0C, "R6 TxEMP set");

        // R6/R7 byte held while disabled, dropped by transmitter reset
        wr(6'h08, 8'h08);
        wr(6'h0C, 8'h3C);
        check(!tx_valid, "R6 disabled no offer", tx_valid, 0);
        rd_chk(6'h04, 8'h00, "R7 disabled pending");
        wr(6'h08, 8'h04);
        check(tx_valid && tx_data == 8'h3C, "R6 offer after enable", {tx_valid, tx_data}, 9'h13C);
        wr(6'h08, 8'h30);
        check(!tx_valid, "R7 reset drops byte", tx_valid, 0);
        rd_chk(6'h04, 8'h08, "R7 reset status");

        // R8 receive FIFO
        check(!rx_ready, "R8 disabled", rx_ready, 0);
        rx_push(8'h77);
        rd_chk(6'h04, 8'h08, "R8 disabled ignored");
        wr(6'h08, 8'h01);
        check(rx_ready, "R8 enabled", rx_ready, 1);
        rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
        rd_chk(6'h04, 8'h09, "R8 not empty");
        rd_chk(6'h14, 8'h00, "R10 full-select not full");
        rx_push(8'h44);
        rd_chk(6'h04, 8'h0B, "R8 full");
        check(!rx_ready, "R8 full stalls", rx_ready, 0);
        rd_chk(6'h14, 8'h02, "R10 full-select full");
        rx_push(8'h55);
        rd_chk(6'h0C, 8'h11, "R8 pop order");
        rd_chk(6'h04, 8'h09, "R8 full cleared");
        rd_chk(6'h0C, 8'h22, "R8 pop order");
        rd_chk(6'h0C, 8'h33, "R8 pop order");
        rd_chk(6'h0C, 8'h44, "R8 full push ignored");
        rd_chk(6'h0C, 8'h00, "R8 empty read");
        rd_chk(6'h04, 8'h08, "R8 empty status");

        // R10 mask and ready-select, R11 hold
        wr(6'h08, 8'h10);
        wr(6'h00, 8'h00);
        wr(6'h14, 8'h02);
        check(!irq_out, "R10 masked idle", irq_out, 0);
        rx_push(8'h66);
        check(irq_out, "R10 ready-select irq", irq_out, 1);
        wr(6'h14, 8'h00);
        check(!irq_out, "R10 mask off", irq_out, 0);
        check(bus_rdata == 8'h08, "R11 rdata hold", bus_rdata, 8'h08);
        rd_chk(6'h0C, 8'h66, "R8 pop");

        // R9 break while receiver disabled
        wr(6'h08, 8'h02);
        brk_pulse();
        rd_chk(6'h04, 8'h09, "R9 break byte");
        rd_chk(6'h14, 8'h06, "R9 break flag");
        wr(6'h14, 8'h04);
        check(irq_out, "R9 break irq", irq_out, 1);
        rd_chk(6'h0C, 8'h00, "R9 zero byte");
        rd_chk(6'h14, 8'h04, "R9 flag sticky");
        wr(6'h08, 8'h50);
        check(!irq_out, "R9 flag cleared irq", irq_out, 0);
        rd_chk(6'h14, 8'h00, "R9 flag cleared");
        wr(6'h14, 8'h00);

        // R9 break replaces newest entry when full
        wr(6'h08, 8'h01);
        rx_push(8'h01); rx_push(8'h02); rx_push(8'h03); rx_push(8'h04);
        brk_pulse();
        rd_chk(6'h0C, 8'h01, "R9 overwrite keep");
        rd_chk(6'h0C, 8'h02, "R9 overwrite keep");
        rd_chk(6'h0C, 8'h03, "R9 overwrite keep");
        rd_chk(6'h0C, 8'h00, "R9 overwrite newest");
        wr(6'h08, 8'h50);

        // R5 receiver reset
        rx_push(8'hAA); rx_push(8'hBB);
        wr(6'h08, 8'h20);
        rd_chk(6'h04, 8'h08, "R5 status");
        check(!rx_ready, "R5 disabled", rx_ready, 0);
        rd_chk(6'h0C, 8'h00, "R5 emptied");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule